// File: doc/BRIEF.md
# Demodulated Data Output Conditioner

This block turns the raw one-bit output of a radio demodulator into a clean data line for a host microcontroller. The raw level first passes through a two-flop synchroniser. It is then looked at only on a slow enable tick divided down from the system clock, so the output can change only on a tick, and the time between any two output edges is a whole number of tick periods.

Two timing guards shape the line. A level, once driven, is held for at least a minimum number of ticks. This removes spikes and limits how often the host sees an interrupt. The output is also never allowed to stay low longer than a low limit. When the limit is reached, the block drives a high pulse of exactly the minimum width and then returns low. While the raw input stays low, this repeats as a keep-alive pattern, so the host can tell the receiver is still running and always gets a bounded window to reach it over the data line.

A two-bit rate range picks the tick divisor and both limits. The range is captured only while receiving mode is off. While receiving mode is off, the line is driven high and all timing state is cleared.

Top module: `rxdata_shaper`

## Requirements
- R1: While `rx_en` is low, `data_out` is high from the clock edge after `rx_en` is sampled low, and all timing state is cleared. With `raw_in` already low, the first falling edge after `rx_en` rises comes exactly min·div − 1 clock cycles after the first edge that samples `rx_en` high.
- R2: `data_out` changes only on a clock edge where the tick is active. While enabled, every interval between output edges is an integer multiple of the tick period div.
- R3: For rate range s (0..3), div = BASE_DIV·2^(3−s) clock cycles, min = MIN_TICKS + s ticks and low = LOW_TICKS + 4·s ticks. The defaults are 4, 2 and 10.
- R4: Two output edges are never closer than min ticks. A raw low pulse exactly one tick wide, on a high line, is stretched into a low output pulse of exactly min ticks.
- R5: A raw input whose levels each last a whole number H of ticks, with min ≤ H < low, appears at the output with every edge interval equal to H ticks.
- R6: `data_out` never stays low longer than low ticks. While the raw input stays low, the output rises exactly low ticks after it fell.
- R7: A high pulse forced by the low limit lasts exactly min ticks if the raw input is still low. The low-for-low, high-for-min pattern then repeats.
- R8: If the raw input is high when the forced pulse reaches min ticks, the output stays high and the pattern stops.
- R9: `rate_sel` is captured only while `rx_en` is low. A change of `rate_sel` while enabled has no effect on any interval until the next disabled period.
- R10: While `rst_n` is low, `data_out` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_en | input | 1 | Receiving-mode enable; low forces the output high and clears timing |
| rate_sel | input | 2 | Rate range select, captured while `rx_en` is low |
| raw_in | input | 1 | Raw asynchronous demodulator output |
| data_out | output | 1 | Conditioned data line to the host |

## Verification
The hardest state to reach is the end of a forced keep-alive pulse with the raw input already high again. The raw change has to reach the synchroniser while the forced pulse is still running, and the raw input must have stayed low for a full low-limit window before that. The stimulus waits for the forced rising edge, raises the raw input at once, and then watches for the missing falling edge over a window longer than the minimum hold. Spike stretching is made deterministic by holding the raw input low for exactly one tick period, so that exactly one tick samples it.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  localparam int unsigned RATE_NUM = 4;

  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } lvl_e;

  // clock cycles per tick for a rate range (range 0 is the slowest)
  function automatic int unsigned rate_div(input int unsigned base, input int unsigned sel);
    return base << (3 - sel);
  endfunction

  // minimum hold between output edges, in ticks
  function automatic int unsigned rate_min(input int unsigned base, input int unsigned sel);
    return base + sel;
  endfunction

  // longest permitted low run, in ticks
  function automatic int unsigned rate_low(input int unsigned base, input int unsigned sel);
    return base + 4 * sel;
  endfunction

endpackage

// File: rtl/rxs_sync.sv
module rxs_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_n;

  always_comb begin
    sh_n = {sh_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= {STAGES{RST_VAL}};
    end else begin
      sh_q <= sh_n;
    end
  end

  assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/rxs_tick.sv
module rxs_tick #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [CW-1:0] div_m1_i,
  output logic          tick_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_n;
  logic          wrap;

  assign wrap = (cnt_q == div_m1_i);

  always_comb begin
    if (!en_i) begin
      cnt_n = '0;
    end else if (wrap) begin
      cnt_n = '0;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
    end
  end

  assign tick_o = en_i && wrap;

endmodule

// File: rtl/rxs_shaper.sv
module rxs_shaper
  import rxs_pkg::*;
#(
  parameter int unsigned TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          raw_i,
  input  logic [TW-1:0] min_t_i,
  input  logic [TW-1:0] low_t_i,
  output logic          data_o
);

  lvl_e          lvl_q, lvl_n;
  logic [TW-1:0] hold_q, hold_n;
  logic [TW-1:0] low_q, low_n;
  logic [TW-1:0] hold_inc, low_inc;
  logic          hold_met;
  logic          upd;

  assign hold_inc = (hold_q == '1) ? hold_q : hold_q + 1'b1;
  assign low_inc  = (low_q == '1) ? low_q : low_q + 1'b1;
  assign hold_met = (hold_inc >= min_t_i);
  assign upd      = !en_i || tick_i;

  always_comb begin
    lvl_n  = lvl_q;
    hold_n = hold_q;
    low_n  = low_q;
    if (!en_i) begin
      lvl_n  = LVL_HIGH;
      hold_n = '0;
      low_n  = '0;
    end else if (tick_i) begin
      hold_n = hold_inc;
      unique case (lvl_q)
        LVL_HIGH: begin
          if (!raw_i && hold_met) begin
            lvl_n  = LVL_LOW;
            hold_n = '0;
            low_n  = '0;
          end
        end
        LVL_LOW: begin
          low_n = low_inc;
          // the low limit forces a rise; the table keeps low > min
          if ((low_inc >= low_t_i) || (raw_i && hold_met)) begin
            lvl_n  = LVL_HIGH;
            hold_n = '0;
            low_n  = '0;
          end
        end
        default: begin
          lvl_n = LVL_HIGH;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= LVL_HIGH;
      hold_q <= '0;
      low_q  <= '0;
    end else if (upd) begin
      lvl_q  <= lvl_n;
      hold_q <= hold_n;
      low_q  <= low_n;
    end
  end

  assign data_o = (lvl_q == LVL_HIGH);

endmodule

// File: rtl/rxdata_shaper.sv
module rxdata_shaper
  import rxs_pkg::*;
#(
  parameter int unsigned BASE_DIV  = 4,
  parameter int unsigned MIN_TICKS = 2,
  parameter int unsigned LOW_TICKS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic [1:0] rate_sel,
  input  logic       raw_in,
  output logic       data_out
);

  localparam int unsigned DIV_MAX  = BASE_DIV << 3;
  localparam int unsigned DIV_W    = $clog2(DIV_MAX);
  localparam int unsigned TICK_MAX = LOW_TICKS + MIN_TICKS + 12;
  localparam int unsigned TW       = $clog2(TICK_MAX + 1);

  logic             rst_sn;
  logic             raw_s;
  logic             tick;
  logic [1:0]       sel_q;
  logic [DIV_W-1:0] divm1_tab [RATE_NUM];
  logic [TW-1:0]    min_tab   [RATE_NUM];
  logic [TW-1:0]    low_tab   [RATE_NUM];

  rxs_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (1'b1),
    .q_o   (rst_sn)
  );

  rxs_sync #(.STAGES(2), .RST_VAL(1'b0)) u_raw_sync (
    .clk   (clk),
    .rst_n (rst_sn),
    .d_i   (raw_in),
    .q_o   (raw_s)
  );

  for (genvar g = 0; g < RATE_NUM; g++) begin : g_rate
    localparam int unsigned DV = rate_div(BASE_DIV, g);
    localparam int unsigned MV = rate_min(MIN_TICKS, g);
    localparam int unsigned LV = rate_low(LOW_TICKS, g);
    assign divm1_tab[g] = DIV_W'(DV - 1);
    assign min_tab[g]   = TW'(MV);
    assign low_tab[g]   = TW'(LV);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sel_q <= '0;
    end else if (!rx_en) begin
      sel_q <= rate_sel;
    end
  end

  rxs_tick #(.CW(DIV_W)) u_tick (
    .clk      (clk),
    .rst_n    (rst_sn),
    .en_i     (rx_en),
    .div_m1_i (divm1_tab[sel_q]),
    .tick_o   (tick)
  );

  rxs_shaper #(.TW(TW)) u_shape (
    .clk     (clk),
    .rst_n   (rst_sn),
    .en_i    (rx_en),
    .tick_i  (tick),
    .raw_i   (raw_s),
    .min_t_i (min_tab[sel_q]),
    .low_t_i (low_tab[sel_q]),
    .data_o  (data_out)
  );

endmodule

// File: rtl/rxdata_shaper_chk.sv
module rxdata_shaper_chk #(
  parameter int unsigned BASE_DIV  = 4,
  parameter int unsigned MIN_TICKS = 2,
  parameter int unsigned LOW_TICKS = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       data_out,
  input logic       tick,
  input logic [1:0] sel_q
);

  logic        prev_q;
  logic        en_d;
  logic        tick_d;
  logic [15:0] run_q;
  logic [15:0] lowrun_q;
  logic        edge_seen;
  logic [31:0] min_cyc;
  logic [31:0] low_cyc;

  assign edge_seen = (data_out != prev_q);

  always_comb begin
    min_cyc = rxs_pkg::rate_div(BASE_DIV, {30'b0, sel_q}) *
              rxs_pkg::rate_min(MIN_TICKS, {30'b0, sel_q});
    low_cyc = rxs_pkg::rate_div(BASE_DIV, {30'b0, sel_q}) *
              rxs_pkg::rate_low(LOW_TICKS, {30'b0, sel_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b1;
      en_d     <= 1'b0;
      tick_d   <= 1'b0;
      run_q    <= '0;
      lowrun_q <= '0;
    end else begin
      prev_q <= data_out;
      en_d   <= rx_en;
      tick_d <= tick;
      if (!rx_en || edge_seen) begin
        run_q <= '0;
      end else if (run_q != '1) begin
        run_q <= run_q + 1'b1;
      end
      if (!rx_en || data_out) begin
        lowrun_q <= '0;
      end else if (lowrun_q != '1) begin
        lowrun_q <= lowrun_q + 1'b1;
      end
    end
  end

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> data_out);

  assert_edge_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && en_d && edge_seen) |-> tick_d);

  assert_min_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && en_d && edge_seen) |-> ({16'b0, run_q} + 32'd1 >= min_cyc));

  assert_low_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && en_d && !data_out) |-> ({16'b0, lowrun_q} < low_cyc));

  assert_range_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && en_d) |-> $stable(sel_q));

endmodule

bind rxdata_shaper rxdata_shaper_chk #(
  .BASE_DIV  (BASE_DIV),
  .MIN_TICKS (MIN_TICKS),
  .LOW_TICKS (LOW_TICKS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_en    (rx_en),
  .data_out (data_out),
  .tick     (tick),
  .sel_q    (sel_q)
);

// File: tb/rxdata_shaper_tb.sv
`timescale 1ns/1ps
module rxdata_shaper_tb;

  localparam int BASE_DIV  = 4;
  localparam int MIN_TICKS = 2;
  localparam int LOW_TICKS = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_en;
  logic [1:0] rate_sel;
  logic       raw_in;
  logic       data_out;

  int checks = 0;
  int errs   = 0;
  int cyc    = 0;
  bit done   = 0;

  // edge log filled by the monitor
  int   ev_cnt = 0;
  int   ev_cyc = 0;
  logic ev_lvl = 1'b1;
  int   hist [64];
  logic mon_prev = 1'b1;
  bit   mon_on = 0;
  bit   have_last = 0;
  int   last_cyc = 0;
  int   cur_div = 1;
  int   cur_min = 1;
  int   cur_low = 1;

  rxdata_shaper #(
    .BASE_DIV  (BASE_DIV),
    .MIN_TICKS (MIN_TICKS),
    .LOW_TICKS (LOW_TICKS)
  ) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .rate_sel (rate_sel),
    .raw_in   (raw_in),
    .data_out (data_out)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int e_div(input int s); return BASE_DIV << (3 - s); endfunction
  function automatic int e_min(input int s); return MIN_TICKS + s; endfunction
  function automatic int e_low(input int s); return LOW_TICKS + 4 * s; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && data_out !== mon_prev) begin
      ev_cnt++;
      ev_cyc = cyc;
      ev_lvl = data_out;
      hist[ev_cnt % 64] = cyc;
      if (mon_on) begin
        if (have_last) begin
          int dt;
          dt = cyc - last_cyc;
          chk(dt % cur_div == 0, "R2 edge off tick grid", dt % cur_div, 0);
          chk(dt >= cur_min * cur_div, "R4 edges too close", dt, cur_min * cur_div);
          if (data_out == 1'b1)
            chk(dt <= cur_low * cur_div, "R6 low run too long", dt, cur_low * cur_div);
        end
        have_last = 1;
        last_cyc  = cyc;
      end
      mon_prev = data_out;
    end
  end

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic next_edge(output int c, output logic l);
    int start;
    int w;
    start = ev_cnt;
    w = 0;
    while (ev_cnt == start && w < 4000) begin
      step(1);
      w++;
    end
    if (ev_cnt == start) chk(0, "R6 no output edge", 0, 1);
    c = ev_cyc;
    l = ev_lvl;
  endtask

  task automatic enable_at(input int s, output int c0);
    cur_div  = e_div(s);
    cur_min  = e_min(s);
    cur_low  = e_low(s);
    rate_sel = 2'(s);
    step(4);
    have_last = 0;
    mon_on = 1;
    rx_en = 1'b1;
    step(1);
    c0 = cyc;
  endtask

  task automatic run_range(input int s);
    int d, mn, lw, h, e0;
    int c0, c1, c2, c3, c4, cx;
    logic l;
    d  = e_div(s);
    mn = e_min(s);
    lw = e_low(s);
    raw_in = 1'b0;
    enable_at(s, c0);
    // R1: cleared counters, first fall after exactly min ticks
    next_edge(c1, l);
    chk(c1 - c0 == mn * d - 1 && l == 1'b0, "R1 first fall", c1 - c0, mn * d - 1);
    // R3 R6: low limit in the table's tick count
    next_edge(c2, l);
    chk(c2 - c1 == lw * d && l == 1'b1, "R6 R3 low limit", c2 - c1, lw * d);
    // R7: forced pulse and repetition
    next_edge(c3, l);
    chk(c3 - c2 == mn * d && l == 1'b0, "R7 keep-alive width", c3 - c2, mn * d);
    next_edge(c4, l);
    chk(c4 - c3 == lw * d && l == 1'b1, "R7 repeat low", c4 - c3, lw * d);
    // R8: raw goes high during the forced pulse
    raw_in = 1'b1;
    e0 = ev_cnt;
    step((mn + 3) * d);
    chk(ev_cnt == e0 && data_out == 1'b1, "R8 pattern stops", ev_cnt - e0, 0);
    // R5: tracking of a slow raw pattern
    h  = mn + 2;
    e0 = ev_cnt;
    for (int k = 0; k < 8; k++) begin
      raw_in = (k % 2 == 0) ? 1'b0 : 1'b1;
      step(h * d);
    end
    step(d + 4);
    chk(ev_cnt - e0 == 8, "R5 edge count", ev_cnt - e0, 8);
    for (int i = 1; i < 8; i++) begin
      chk(hist[(e0 + i + 1) % 64] - hist[(e0 + i) % 64] == h * d, "R5 interval",
          hist[(e0 + i + 1) % 64] - hist[(e0 + i) % 64], h * d);
    end
    // R4: one-tick raw spike stretched to min ticks
    step((mn + 1) * d);
    e0 = ev_cnt;
    raw_in = 1'b0;
    step(d);
    raw_in = 1'b1;
    step((mn + 3) * d);
    chk(ev_cnt - e0 == 2, "R4 spike edges", ev_cnt - e0, 2);
    chk(hist[(e0 + 2) % 64] - hist[(e0 + 1) % 64] == mn * d, "R4 spike width",
        hist[(e0 + 2) % 64] - hist[(e0 + 1) % 64], mn * d);
    // R1: disable while low forces high
    raw_in = 1'b0;
    next_edge(cx, l);
    mon_on = 0;
    rx_en = 1'b0;
    step(1);
    chk(data_out == 1'b1, "R1 forced high", data_out, 1);
    step(3);
  endtask

  initial begin
    rst_n = 1'b1;
    rx_en = 1'b0;
    rate_sel = 2'd0;
    raw_in = 1'b0;
    #1 rst_n = 1'b0;
    step(3);
    chk(data_out == 1'b1, "R10 reset level", data_out, 1);
    rst_n = 1'b1;
    step(5);
    chk(data_out == 1'b1, "R1 idle level", data_out, 1);

    for (int s = 0; s < 4; s++) run_range(s);

    // R9: range change while enabled is ignored
    begin
      int c0, c1, c2, c3;
      logic l;
      raw_in = 1'b0;
      enable_at(0, c0);
      next_edge(c1, l);
      rate_sel = 2'd3;
      next_edge(c2, l);
      chk(c2 - c1 == e_low(0) * e_div(0), "R9 low limit kept", c2 - c1, e_low(0) * e_div(0));
      next_edge(c3, l);
      chk(c3 - c2 == e_min(0) * e_div(0), "R9 pulse kept", c3 - c2, e_min(0) * e_div(0));
      mon_on = 0;
      rx_en = 1'b0;
      step(3);
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errs++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule